// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit processor that runs a small load/store instruction subset: word load, word store, register-register arithmetic and logic, branch on equal, and jump. Each instruction takes three to five clock cycles. In each cycle the datapath uses at most one of its three large resources: a single ALU, a single memory port shared by instructions and data, and a single register file. Values that one step produces and a later step needs are held in internal registers. These are the program counter, an instruction latch, a loaded-data latch, two operand latches and a result latch.

The datapath does not sequence itself. An external controller drives every write strobe and multiplexer select, cycle by cycle. The datapath returns the opcode of the latched instruction and the zero flag of the ALU to that controller. The memory sits outside the block. The datapath gives it an address, write data and read/write strobes. Read data comes back in the same cycle, and a write is committed by the memory at the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: While rst_ni is low, the program counter and all holding latches are zero and every register reads as zero. This is seen as mem_addr_o = 0 for both address selects, mem_wdata_o = 0 and opcode_o = 0.
- R2: mem_addr_o is the program counter when iord_i = 0. It is the ALU result latch when iord_i = 1.
- R3: The instruction latch captures mem_rdata_i at an edge only when ir_wr_i = 1. Otherwise opcode_o keeps its value.
- R4: The first ALU operand is the program counter when alu_src_a_i = 0 and operand latch A when it is 1. The second operand is selected by alu_src_b_i: 00 gives operand latch B, 01 gives the constant 4, 10 gives the sign-extended instruction bits [15:0], and 11 gives that value shifted left by 2.
- R5: alu_op_i = 00 makes the ALU add and 01 makes it subtract. With 10, the ALU decodes instruction bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Any other function code, and alu_op_i = 11, give an add.
- R6: zero_o is 1 exactly when the live ALU result is zero.
- R7: The program counter loads at an edge when pc_wr_i = 1, or when pc_wr_cond_i = 1 and zero_o = 1. pc_src_i selects the value: 00 gives the live ALU result, 01 gives the ALU result latch, 10 gives the jump target.
- R8: The jump target is the top 4 bits of the program counter, followed by instruction bits [25:0], followed by two zero bits.
- R9: Registers are read at instruction bits [25:21] (into A) and [20:16] (into B). The write address is bits [20:16] when reg_dst_i = 0 and bits [15:11] when it is 1. The write data is the ALU result latch when mem_to_reg_i = 0 and the loaded-data latch when it is 1. The write is applied at the edge when reg_wr_i = 1.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: mem_wdata_o is operand latch B. mem_rd_o and mem_wr_o follow mem_rd_i and mem_wr_i.
- R12: opcode_o is instruction latch bits [31:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_wr_i | input | 1 | Unconditional program counter load |
| pc_wr_cond_i | input | 1 | Program counter load when the ALU result is zero |
| pc_src_i | input | 2 | Next program counter select |
| iord_i | input | 1 | Memory address select: 0 program counter, 1 result latch |
| mem_rd_i | input | 1 | Memory read request from the controller |
| mem_wr_i | input | 1 | Memory write request from the controller |
| ir_wr_i | input | 1 | Instruction latch enable |
| mem_to_reg_i | input | 1 | Register write data select |
| reg_dst_i | input | 1 | Register write address select |
| reg_wr_i | input | 1 | Register file write enable |
| alu_src_a_i | input | 1 | First ALU operand select |
| alu_src_b_i | input | 2 | Second ALU operand select |
| alu_op_i | input | 2 | ALU operation class |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid in the same cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| opcode_o | output | 6 | Opcode of the latched instruction |
| zero_o | output | 1 | Live ALU result equals zero |

## Verification
Two things share the fetch edge. The instruction latch captures the word addressed by the old program counter, and at the same edge the program counter takes the sum the ALU is producing. A branch cycle has the same kind of overlap: the live zero flag from the A-B subtraction decides whether the branch target, computed and latched one cycle earlier, goes into the program counter, and the result latch is overwritten at that same edge. The bench steps both cases through full instruction sequences, with directed and random operand pairs that are equal and unequal. It judges the outcome from the opcode after fetch and from the address presented at the next fetch, and compares these with a model of the program counter and register file kept in the bench.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT
  } alu_fn_e;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

  localparam logic [1:0] SRCB_REG    = 2'b00;
  localparam logic [1:0] SRCB_FOUR   = 2'b01;
  localparam logic [1:0] SRCB_IMM    = 2'b10;
  localparam logic [1:0] SRCB_IMM_SH = 2'b11;

  localparam logic [1:0] PCSRC_ALU   = 2'b00;
  localparam logic [1:0] PCSRC_LATCH = 2'b01;
  localparam logic [1:0] PCSRC_JUMP  = 2'b10;
endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int REG_AW = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra1_i,
  input  logic [REG_AW-1:0] ra2_i,
  input  logic [REG_AW-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] rd2_o
);
  logic [DATA_W-1:0] regs_q [1:REG_N-1];

  // entry 0 has no storage
  for (genvar g = 1; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && wa_i == REG_AW'(g))       regs_q[g] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/mc_alu_ctrl.sv
`timescale 1ns/1ps
module mc_alu_ctrl
  import mc_pkg::*;
(
  input  logic [1:0] alu_op_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o
);
  always_comb begin
    unique case (alu_op_i)
      AOP_ADD: fn_o = FN_ADD;
      AOP_SUB: fn_o = FN_SUB;
      AOP_FUNCT: begin
        unique case (funct_i)
          FC_SUB:  fn_o = FN_SUB;
          FC_AND:  fn_o = FN_AND;
          FC_OR:   fn_o = FN_OR;
          FC_SLT:  fn_o = FN_SLT;
          default: fn_o = FN_ADD;
        endcase
      end
      default: fn_o = FN_ADD;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  logic lt;
  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (fn_i)
      FN_SUB:  res_o = a_i - b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_SLT:  res_o = {{(DATA_W-1){1'b0}}, lt};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_wr_i,
  input  logic              pc_wr_cond_i,
  input  logic [1:0]        pc_src_i,
  input  logic              iord_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              ir_wr_i,
  input  logic              mem_to_reg_i,
  input  logic              reg_dst_i,
  input  logic              reg_wr_i,
  input  logic              alu_src_a_i,
  input  logic [1:0]        alu_src_b_i,
  input  logic [1:0]        alu_op_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [5:0]        opcode_o,
  output logic              zero_o
);
  localparam int REG_AW = $clog2(REG_N);
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;
  localparam int OP_LSB = DATA_W - 6;

  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [DATA_W-1:0] rd1, rd2, src_a, src_b, alu_res;
  logic [DATA_W-1:0] imm_ext, imm_sh, jmp_tgt, pc_next, wb_data;
  logic [REG_AW-1:0] wr_addr;
  alu_fn_e           alu_fn;
  logic              alu_zero, pc_load;

  assign imm_ext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh  = {imm_ext[DATA_W-3:0], 2'b00};
  assign jmp_tgt = {pc_q[DATA_W-1:DATA_W-4], ir_q[JMP_W-1:0], 2'b00};

  assign wr_addr = reg_dst_i ? ir_q[15:11] : ir_q[20:16];
  assign wb_data = mem_to_reg_i ? mdr_q : aluout_q;

  mc_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (ir_q[25:21]),
    .ra2_i  (ir_q[20:16]),
    .wa_i   (wr_addr),
    .wd_i   (wb_data),
    .we_i   (reg_wr_i),
    .rd1_o  (rd1),
    .rd2_o  (rd2)
  );

  assign src_a = alu_src_a_i ? a_q : pc_q;

  always_comb begin
    unique case (alu_src_b_i)
      SRCB_REG:  src_b = b_q;
      SRCB_FOUR: src_b = DATA_W'(4);
      SRCB_IMM:  src_b = imm_ext;
      default:   src_b = imm_sh;
    endcase
  end

  mc_alu_ctrl u_actl (
    .alu_op_i (alu_op_i),
    .funct_i  (ir_q[5:0]),
    .fn_o     (alu_fn)
  );

  mc_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i    (src_a),
    .b_i    (src_b),
    .fn_i   (alu_fn),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  always_comb begin
    unique case (pc_src_i)
      PCSRC_LATCH: pc_next = aluout_q;
      PCSRC_JUMP:  pc_next = jmp_tgt;
      default:     pc_next = alu_res;
    endcase
  end

  assign pc_load = pc_wr_i | (pc_wr_cond_i & alu_zero);

  // only pc and ir are enabled; the other latches refresh every edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_wr_i) ir_q <= mem_rdata_i;
      mdr_q    <= mem_rdata_i;
      a_q      <= rd1;
      b_q      <= rd2;
      aluout_q <= alu_res;
    end
  end

  assign mem_addr_o  = iord_i ? aluout_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_rd_o    = mem_rd_i;
  assign mem_wr_o    = mem_wr_i;
  assign opcode_o    = ir_q[DATA_W-1:OP_LSB];
  assign zero_o      = alu_zero;
endmodule

// File: rtl/mc_datapath_chk.sv
`timescale 1ns/1ps
module mc_datapath_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pc_wr_i,
  input logic              pc_wr_cond_i,
  input logic [1:0]        pc_src_i,
  input logic              ir_wr_i,
  input logic              zero_i,
  input logic [5:0]        mem_op_i,
  input logic [5:0]        opcode_i,
  input logic [DATA_W-1:0] pc_q,
  input logic [DATA_W-1:0] alu_res
);
  assert_pc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_wr_i && !(pc_wr_cond_i && zero_i)) |=> $stable(pc_q));

  assert_pc_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_i && pc_src_i == 2'b00) |=> (pc_q == $past(alu_res)));

  assert_jump_form_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_i && pc_src_i == 2'b10) |=>
      (pc_q[1:0] == 2'b00 && pc_q[DATA_W-1:DATA_W-4] == $past(pc_q[DATA_W-1:DATA_W-4])));

  assert_ir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_wr_i |=> $stable(opcode_i));

  assert_ir_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_i |=> (opcode_i == $past(mem_op_i)));
endmodule

bind mc_datapath mc_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_wr_i      (pc_wr_i),
  .pc_wr_cond_i (pc_wr_cond_i),
  .pc_src_i     (pc_src_i),
  .ir_wr_i      (ir_wr_i),
  .zero_i       (zero_o),
  .mem_op_i     (mem_rdata_i[DATA_W-1:DATA_W-6]),
  .opcode_i     (opcode_o),
  .pc_q         (pc_q),
  .alu_res      (alu_res)
);

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr;
  logic        mem_to_reg, reg_dst, reg_wr, src_a;
  logic [1:0]  pc_src, src_b, alu_op;
  logic [31:0] rdata;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rd_o, mem_wr_o, zero_o;
  logic [5:0]  opcode_o;

  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;
  logic [31:0] gr [32];
  logic [31:0] gpc;

  always #2.5 clk_i = ~clk_i;

  mc_datapath u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_wr_i(pc_wr), .pc_wr_cond_i(pc_wr_cond),
    .pc_src_i(pc_src), .iord_i(iord), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .ir_wr_i(ir_wr), .mem_to_reg_i(mem_to_reg), .reg_dst_i(reg_dst),
    .reg_wr_i(reg_wr), .alu_src_a_i(src_a), .alu_src_b_i(src_b),
    .alu_op_i(alu_op), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(rdata), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .opcode_o(opcode_o), .zero_o(zero_o)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_r(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] r_ins(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] f);
    return {6'h00, rs, rt, rd, 5'd0, f};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; pc_src = 0; iord = 0; mem_rd = 0; mem_wr = 0;
    ir_wr = 0; mem_to_reg = 0; reg_dst = 0; reg_wr = 0; src_a = 0; src_b = 0; alu_op = 0;
  endtask

  task automatic fetch(input logic [31:0] ins);
    idle(); mem_rd = 1; ir_wr = 1; src_b = 2'b01; pc_wr = 1; rdata = ins;
    #1;
    chk(mem_addr_o == gpc, "R2 R7 fetch address", mem_addr_o, gpc);
    chk(mem_rd_o == 1'b1, "R11 read strobe", 32'(mem_rd_o), 32'd1);
    tick();
    gpc = gpc + 32'd4;
    chk(opcode_o == ins[31:26], "R12 opcode", 32'(opcode_o), 32'(ins[31:26]));
    idle(); src_b = 2'b11;  // decode: target = pc + (imm<<2)
    tick();
  endtask

  task automatic run_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] f);
    fetch(r_ins(rs, rt, rd, f));
    idle(); src_a = 1; alu_op = 2'b10; tick();
    idle(); reg_dst = 1; reg_wr = 1; tick();
    if (rd != 0) gr[rd] = ref_r(f, gr[rs], gr[rt]);
  endtask

  task automatic run_lw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm, input logic [31:0] d);
    logic [31:0] ea;
    ea = gr[rs] + sx(imm);
    fetch(i_ins(6'h23, rs, rt, imm));
    idle(); src_a = 1; src_b = 2'b10; tick();
    idle(); mem_rd = 1; iord = 1; rdata = d;
    #1;
    chk(mem_addr_o == ea, "R2 R4 load address", mem_addr_o, ea);
    tick();
    idle(); mem_to_reg = 1; reg_wr = 1; tick();
    if (rt != 0) gr[rt] = d;
  endtask

  task automatic run_sw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm, input string req);
    logic [31:0] ea;
    ea = gr[rs] + sx(imm);
    fetch(i_ins(6'h2B, rs, rt, imm));
    idle(); src_a = 1; src_b = 2'b10; tick();
    idle(); mem_wr = 1; iord = 1;
    #1;
    chk(mem_addr_o == ea, "R2 R4 store address", mem_addr_o, ea);
    chk(mem_wdata_o == gr[rt], req, mem_wdata_o, gr[rt]);
    chk(mem_wr_o == 1'b1, "R11 write strobe", 32'(mem_wr_o), 32'd1);
    tick();
  endtask

  task automatic run_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    bit eq;
    eq = (gr[rs] == gr[rt]);
    fetch(i_ins(6'h04, rs, rt, imm));
    idle(); src_a = 1; alu_op = 2'b01; pc_wr_cond = 1; pc_src = 2'b01;
    #1;
    chk(zero_o == eq, "R6 branch zero", 32'(zero_o), 32'(eq));
    tick();
    if (eq) gpc = gpc + {sx(imm)[29:0], 2'b00};
  endtask

  task automatic run_j(input logic [25:0] t);
    fetch({6'h02, t});
    idle(); pc_wr = 1; pc_src = 2'b10; tick();
    gpc = {gpc[31:28], t, 2'b00};
  endtask

  task automatic observe(input logic [4:0] r, input string req);
    run_sw(5'd0, r, 16'($urandom), req);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [5:0]  fsel;
    logic [4:0]  ra, rb, rc;
    logic [31:0] hold;
    void'($urandom(32'd4242));
    idle(); rdata = 32'hFFFF_FFFF; rst_ni = 0;
    for (int i = 0; i < 32; i++) gr[i] = '0;
    gpc = '0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    chk(mem_addr_o == 0, "R1 pc reset", mem_addr_o, 0);
    iord = 1; #1;
    chk(mem_addr_o == 0, "R1 result latch reset", mem_addr_o, 0);
    chk(mem_wdata_o == 0, "R1 operand latch reset", mem_wdata_o, 0);
    chk(opcode_o == 0, "R1 instruction latch reset", 32'(opcode_o), 0);
    idle(); rst_ni = 1;
    tick();

    // fill registers
    for (int i = 1; i < 32; i++) run_lw(5'd0, 5'(i), 16'($urandom), $urandom);
    run_lw(5'd0, 5'd1, 16'h0010, 32'h8000_0000);
    run_lw(5'd0, 5'd2, 16'hFFF0, 32'd5);
    // R5 signed slt both ways
    run_r(5'd1, 5'd2, 5'd3, 6'h2A); observe(5'd3, "R5 slt negative");
    run_r(5'd2, 5'd1, 5'd4, 6'h2A); observe(5'd4, "R5 slt positive");
    run_r(5'd1, 5'd2, 5'd5, 6'h22); observe(5'd5, "R5 sub");
    run_r(5'd6, 5'd7, 5'd8, 6'h24); observe(5'd8, "R5 and");
    run_r(5'd6, 5'd7, 5'd9, 6'h25); observe(5'd9, "R5 or");
    run_r(5'd6, 5'd7, 5'd10, 6'h21); observe(5'd10, "R5 unknown funct adds");
    // R10: writes to register 0 dropped
    run_r(5'd6, 5'd7, 5'd0, 6'h20); observe(5'd0, "R10 r0 after alu write");
    run_lw(5'd0, 5'd0, 16'h0004, 32'hDEAD_BEEF); observe(5'd0, "R10 r0 after load");
    // R9 rt vs rd addressing
    run_r(5'd11, 5'd12, 5'd13, 6'h20); observe(5'd12, "R9 rt untouched by rd write");
    observe(5'd13, "R9 rd written");
    // R6 R7 branches taken and not
    run_beq(5'd14, 5'd14, 16'h0003);
    run_beq(5'd0, 5'd0, 16'hFFF8);
    gr[15] = gr[16] ^ 32'h1; run_lw(5'd0, 5'd15, 16'h0, gr[15]);
    run_beq(5'd15, 5'd16, 16'h0040);
    // R8 jump
    run_j(26'h3AB_CDEF);
    run_j(26'h000_0001);
    // R3 instruction latch holds without enable
    fetch(r_ins(5'd1, 5'd2, 5'd3, 6'h20));
    hold = 32'(opcode_o);
    idle(); rdata = 32'hFC00_0000; tick();
    chk(32'(opcode_o) == hold, "R3 hold without enable", 32'(opcode_o), hold);

    // random mix
    for (int i = 0; i < 300; i++) begin
      ra = 5'($urandom); rb = 5'($urandom); rc = 5'($urandom);
      case ($urandom % 6)
        0: fsel = 6'h20;
        1: fsel = 6'h22;
        2: fsel = 6'h24;
        3: fsel = 6'h25;
        4: fsel = 6'h2A;
        default: fsel = 6'($urandom % 16);
      endcase
      case ($urandom % 5)
        0, 1: begin run_r(ra, rb, rc, fsel); observe(rc, "R5 R9 random alu"); end
        2: begin run_lw(ra, rc, 16'($urandom), $urandom); observe(rc, "R9 R10 random load"); end
        3: run_beq(ra, ($urandom % 2) ? ra : rb, 16'($urandom));
        default: run_j(26'($urandom));
      endcase
    end
    fetch(r_ins(5'd0, 5'd0, 5'd0, 6'h20));

    // R1 reset in mid-run
    idle(); rst_ni = 0; #1;
    chk(mem_addr_o == 0, "R1 pc cleared by reset", mem_addr_o, 0);
    chk(opcode_o == 0, "R1 opcode cleared by reset", 32'(opcode_o), 0);
    tick(); rst_ni = 1; tick();
    gpc = '0;
    for (int i = 0; i < 32; i++) gr[i] = '0;
    observe(5'd17, "R1 register cleared by reset");

    done = 1;
    summary();
    $finish;
  end
endmodule